// File: doc/BRIEF.md
# Dual Parallel Port Adapter

This block sits between a processor bus and two 8-bit bidirectional peripheral ports, side A and side B. Each side holds a direction register, an output register and a six-bit control register, plus two interrupt flags. Each line's direction bit decides whether the pin is driven from the output register or left as an input. Each side also watches two control lines. The first is always an edge-sensitive input. The second is either an edge-sensitive input or a simple software-driven output. An active edge on either line latches a flag, and a per-side interrupt request is raised when the flag's enable is set.

Bus accesses are framed by a bus phase strobe that is synchronous to the block clock. Write data and the target address are captured while the strobe is high and the select is asserted. The target register changes only after the strobe falls. A read returns the addressed register at once. Its side effect, clearing the side's flags, takes place after the strobe falls, in the same way as a write.

Top module: `ppa_top`

## Requirements
- R1: After reset every register and flag is zero: all port lines are inputs (`*_pin_oe` = 0, `*_pin_out` = 0), both interrupt outputs are low, both auxiliary lines are undriven, and every register reads back as 0x00.
- R2: A direction bit of 1 makes its line an output: `pin_oe` equals the direction register, and `pin_out` carries the output register bit on output lines and 0 on input lines.
- R3: Select 0 addresses side A data, 1 control A, 2 side B data, 3 control B. At a data address, control bit 2 = 1 selects the output register and 0 selects the direction register, for both reads and writes.
- R4: Write data is captured while `bus_phase` is high and `sel` is asserted. The target register changes only after `bus_phase` falls: the new value is visible on the port outputs two clock edges after the first edge that sees the strobe low, and not before.
- R5: A read of the output register returns the pin input on input lines and the output register on output lines.
- R6: Control bit 7 is set by an active edge on the side's edge input. Control bit 1 selects the active edge: 0 for falling, 1 for rising. The interrupt is raised from bit 7 only when control bit 0 = 1.
- R7: With control bit 5 = 0, the auxiliary line is an input. Bit 4 selects its active edge (1 rising, 0 falling), an active edge sets flag bit 6, and bit 3 enables the interrupt from that flag.
- R8: With control bit 5 = 1, the auxiliary line is driven (`aux_oe` = 1). It carries bit 3 when bit 4 = 1 and is held high when bit 4 = 0. Edges on its input then set no flag.
- R9: A read of a side's output register (bit 2 = 1) clears both of that side's flags. A read of the control register leaves them unchanged.
- R10: Writes to control bits 7 and 6 are ignored, so the flags keep their values.
- R11: The two sides are independent. Accesses and edges on one side change neither the outputs nor the interrupt of the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phase | input | 1 | Bus phase strobe, synchronous to clk |
| sel | input | 1 | Access select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| rs | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when no read is selected) |
| a_pin_in | input | 8 | Side A pin levels |
| a_pin_out | output | 8 | Side A pin drive values |
| a_pin_oe | output | 8 | Side A pin drive enables |
| a_edge_in | input | 1 | Side A edge input |
| a_aux_in | input | 1 | Side A auxiliary line input level |
| a_aux_out | output | 1 | Side A auxiliary line drive value |
| a_aux_oe | output | 1 | Side A auxiliary line drive enable |
| a_irq | output | 1 | Side A interrupt request |
| b_pin_in | input | 8 | Side B pin levels |
| b_pin_out | output | 8 | Side B pin drive values |
| b_pin_oe | output | 8 | Side B pin drive enables |
| b_edge_in | input | 1 | Side B edge input |
| b_aux_in | input | 1 | Side B auxiliary line input level |
| b_aux_out | output | 1 | Side B auxiliary line drive value |
| b_aux_oe | output | 1 | Side B auxiliary line drive enable |
| b_irq | output | 1 | Side B interrupt request |

## Verification
The assertions assume that the bus strobe, select and control inputs are already synchronous to `clk`. They also assume that `sel`, `rs` and `rd_wr` stay steady while the strobe is high. The flag properties assume that an active edge does not land in the very cycle in which a clearing read commits. The stimulus meets these assumptions by changing every input only at falling clock edges, by holding each access steady across two full cycles of strobe high, and by toggling the edge and auxiliary inputs only after the preceding access has fully settled.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    localparam int PPA_W  = 8;
    localparam int CTRL_W = 6;

    typedef enum logic [1:0] {
        SEL_DATA_A = 2'd0,
        SEL_CTRL_A = 2'd1,
        SEL_DATA_B = 2'd2,
        SEL_CTRL_B = 2'd3
    } reg_sel_e;

    // control bit positions
    localparam int CB_E_EN    = 0;
    localparam int CB_E_RISE  = 1;
    localparam int CB_ACC_OUT = 2;
    localparam int CB_X_LVL   = 3;
    localparam int CB_X_SUB   = 4;
    localparam int CB_X_DRIVE = 5;

endpackage

// File: rtl/ppa_bus_capture.sv
module ppa_bus_capture #(
    parameter int W = ppa_pkg::PPA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_phase,
    input  logic         sel,
    input  logic         rd_wr,
    input  logic [1:0]   rs,
    input  logic [W-1:0] wdata,
    output logic         cm_valid,
    output logic         cm_wr,
    output logic [1:0]   cm_rs,
    output logic [W-1:0] cm_data
);

    typedef struct packed {
        logic         ph;
        logic         act;
        logic         wr;
        logic [1:0]   rs;
        logic [W-1:0] data;
        logic         cv;
        logic         cwr;
        logic [1:0]   crs;
        logic [W-1:0] cdata;
    } cap_t;

    cap_t cap_d, cap_q;
    logic fall;

    always_comb begin
        cap_d    = cap_q;
        fall     = cap_q.ph && !bus_phase;
        cap_d.ph = bus_phase;
        cap_d.cv = 1'b0;
        if (fall && cap_q.act) begin
            cap_d.cv    = 1'b1;
            cap_d.cwr   = cap_q.wr;
            cap_d.crs   = cap_q.rs;
            cap_d.cdata = cap_q.data;
        end
        if (bus_phase && sel) begin
            cap_d.act  = 1'b1;
            cap_d.wr   = !rd_wr;
            cap_d.rs   = rs;
            cap_d.data = wdata;
        end else if (fall) begin
            cap_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cm_valid = cap_q.cv;
    assign cm_wr    = cap_q.cwr;
    assign cm_rs    = cap_q.crs;
    assign cm_data  = cap_q.cdata;

    // R4: a commit is a single-cycle event
    p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> !cm_valid);

    // R4: a commit follows a falling strobe
    p_commit_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_valid && cap_q.ph && !bus_phase && cap_q.act) |=> cm_valid);

endmodule

// File: rtl/ppa_side.sv
module ppa_side
    import ppa_pkg::*;
#(
    parameter int W = PPA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_ctrl,
    input  logic              rd_data,
    input  logic [W-1:0]      wdata,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [W-1:0]      pin_in,
    input  logic              edge_in,
    input  logic              aux_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              aux_out,
    output logic              aux_oe,
    output logic              irq,
    output logic [W-1:0]      data_rd,
    output logic [CTRL_W+1:0] ctrl_rd
);

    typedef struct packed {
        logic [W-1:0]      ddr;
        logic [W-1:0]      orr;
        logic [CTRL_W-1:0] cr;
        logic              f1;
        logic              f2;
        logic              e_q;
        logic              x_q;
    } side_t;

    side_t s_d, s_q;
    logic  hit1, hit2;
    logic [W-1:0] port_val;

    always_comb begin
        s_d     = s_q;
        s_d.e_q = edge_in;
        s_d.x_q = aux_in;
        hit1 = (edge_in != s_q.e_q) && (edge_in == s_q.cr[CB_E_RISE]);
        hit2 = !s_q.cr[CB_X_DRIVE] && (aux_in != s_q.x_q)
               && (aux_in == s_q.cr[CB_X_SUB]);
        if (wr_data) begin
            if (s_q.cr[CB_ACC_OUT]) s_d.orr = wdata;
            else                    s_d.ddr = wdata;
        end
        if (wr_ctrl) s_d.cr = ctrl_wdata;
        if (rd_data && s_q.cr[CB_ACC_OUT]) begin
            s_d.f1 = 1'b0;
            s_d.f2 = 1'b0;
        end
        if (hit1) s_d.f1 = 1'b1;
        if (hit2) s_d.f2 = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        port_val = (pin_in & ~s_q.ddr) | (s_q.orr & s_q.ddr);
        data_rd  = s_q.cr[CB_ACC_OUT] ? port_val : s_q.ddr;
        ctrl_rd  = {s_q.f1, s_q.f2, s_q.cr};
        pin_oe   = s_q.ddr;
        pin_out  = s_q.orr & s_q.ddr;
        aux_oe   = s_q.cr[CB_X_DRIVE];
        aux_out  = s_q.cr[CB_X_SUB] ? s_q.cr[CB_X_LVL] : 1'b1;
        irq      = (s_q.f1 & s_q.cr[CB_E_EN])
                 | (s_q.f2 & s_q.cr[CB_X_LVL] & ~s_q.cr[CB_X_DRIVE]);
    end

    // R3: data address writes reach the register picked by bit 2
    p_or_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && s_q.cr[CB_ACC_OUT]) |=> (s_q.orr == $past(wdata)));
    p_ddr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !s_q.cr[CB_ACC_OUT]) |=> (s_q.ddr == $past(wdata)));

    // R6: an active edge on the edge input latches flag 1
    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_in != s_q.e_q) && (edge_in == s_q.cr[CB_E_RISE])) |=> s_q.f1);

    // R9: a clearing read with no concurrent edge empties both flags
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && s_q.cr[CB_ACC_OUT] && !hit1 && !hit2) |=> (!s_q.f1 && !s_q.f2));

    // R10: control writes leave the flags alone
    p_flags_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !rd_data && !hit1 && !hit2) |=>
            (s_q.f1 == $past(s_q.f1) && s_q.f2 == $past(s_q.f2)));

    // R8: a driven auxiliary line never raises flag 2
    p_drive_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cr[CB_X_DRIVE] && !s_q.f2) |=> !s_q.f2);

endmodule

// File: rtl/ppa_top.sv
module ppa_top
    import ppa_pkg::*;
#(
    parameter int W = PPA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_phase,
    input  logic         sel,
    input  logic         rd_wr,
    input  logic [1:0]   rs,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] a_pin_in,
    output logic [W-1:0] a_pin_out,
    output logic [W-1:0] a_pin_oe,
    input  logic         a_edge_in,
    input  logic         a_aux_in,
    output logic         a_aux_out,
    output logic         a_aux_oe,
    output logic         a_irq,
    input  logic [W-1:0] b_pin_in,
    output logic [W-1:0] b_pin_out,
    output logic [W-1:0] b_pin_oe,
    input  logic         b_edge_in,
    input  logic         b_aux_in,
    output logic         b_aux_out,
    output logic         b_aux_oe,
    output logic         b_irq
);

    localparam int NSIDE = 2;

    logic         cm_valid, cm_wr;
    logic [1:0]   cm_rs;
    logic [W-1:0] cm_data;

    logic [NSIDE-1:0][W-1:0]        pin_in_v, pin_out_v, pin_oe_v, data_rd_v;
    logic [NSIDE-1:0][CTRL_W+1:0]   ctrl_rd_v;
    logic [NSIDE-1:0]               edge_v, aux_in_v, aux_out_v, aux_oe_v, irq_v;

    ppa_bus_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_phase(bus_phase),
        .sel      (sel),
        .rd_wr    (rd_wr),
        .rs       (rs),
        .wdata    (wdata),
        .cm_valid (cm_valid),
        .cm_wr    (cm_wr),
        .cm_rs    (cm_rs),
        .cm_data  (cm_data)
    );

    assign pin_in_v[0] = a_pin_in;
    assign pin_in_v[1] = b_pin_in;
    assign edge_v      = {b_edge_in, a_edge_in};
    assign aux_in_v    = {b_aux_in, a_aux_in};

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        localparam logic [1:0] RS_DATA = 2'(2 * g);
        localparam logic [1:0] RS_CTRL = 2'(2 * g + 1);

        logic hit_data, hit_ctrl;
        assign hit_data = cm_valid && (cm_rs == RS_DATA);
        assign hit_ctrl = cm_valid && (cm_rs == RS_CTRL);

        ppa_side #(.W(W)) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_data   (hit_data && cm_wr),
            .wr_ctrl   (hit_ctrl && cm_wr),
            .rd_data   (hit_data && !cm_wr),
            .wdata     (cm_data),
            .ctrl_wdata(cm_data[CTRL_W-1:0]),
            .pin_in    (pin_in_v[g]),
            .edge_in   (edge_v[g]),
            .aux_in    (aux_in_v[g]),
            .pin_out   (pin_out_v[g]),
            .pin_oe    (pin_oe_v[g]),
            .aux_out   (aux_out_v[g]),
            .aux_oe    (aux_oe_v[g]),
            .irq       (irq_v[g]),
            .data_rd   (data_rd_v[g]),
            .ctrl_rd   (ctrl_rd_v[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (sel && rd_wr) begin
            case (reg_sel_e'(rs))
                SEL_DATA_A: rdata = data_rd_v[0];
                SEL_CTRL_A: rdata = W'(ctrl_rd_v[0]);
                SEL_DATA_B: rdata = data_rd_v[1];
                default:    rdata = W'(ctrl_rd_v[1]);
            endcase
        end
    end

    assign a_pin_out = pin_out_v[0];
    assign a_pin_oe  = pin_oe_v[0];
    assign a_aux_out = aux_out_v[0];
    assign a_aux_oe  = aux_oe_v[0];
    assign a_irq     = irq_v[0];
    assign b_pin_out = pin_out_v[1];
    assign b_pin_oe  = pin_oe_v[1];
    assign b_aux_out = aux_out_v[1];
    assign b_aux_oe  = aux_oe_v[1];
    assign b_irq     = irq_v[1];

    // R11: a commit aimed at side A leaves side B's drive untouched
    p_side_isolation_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_rs[1]) |=> $stable(b_pin_oe) && $stable(b_pin_out));

endmodule

// File: tb/ppa_top_tb.sv
module ppa_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_phase = 1'b0, sel = 1'b0, rd_wr = 1'b0;
    logic [1:0] rs = 2'd0;
    logic [7:0] wdata = 8'h00, rdata;
    logic [7:0] a_pin_in = 8'h00, a_pin_out, a_pin_oe;
    logic [7:0] b_pin_in = 8'h00, b_pin_out, b_pin_oe;
    logic       a_edge_in = 1'b0, a_aux_in = 1'b0, a_aux_out, a_aux_oe, a_irq;
    logic       b_edge_in = 1'b0, b_aux_in = 1'b0, b_aux_out, b_aux_oe, b_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ppa_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .sel(sel),
        .rd_wr(rd_wr), .rs(rs), .wdata(wdata), .rdata(rdata),
        .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
        .a_edge_in(a_edge_in), .a_aux_in(a_aux_in), .a_aux_out(a_aux_out),
        .a_aux_oe(a_aux_oe), .a_irq(a_irq),
        .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
        .b_edge_in(b_edge_in), .b_aux_in(b_aux_in), .b_aux_out(b_aux_out),
        .b_aux_oe(b_aux_oe), .b_irq(b_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] r, input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; rd_wr = 1'b0; rs = r; wdata = v; bus_phase = 1'b1;
        repeat (2) @(negedge clk);
        bus_phase = 1'b0; sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] r, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; rd_wr = 1'b1; rs = r; bus_phase = 1'b1;
        @(negedge clk);
        v = rdata;
        @(negedge clk);
        bus_phase = 1'b0; sel = 1'b0; rd_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 a_pin_oe", a_pin_oe, 8'h00);
        chk("R1 b_pin_oe", b_pin_oe, 8'h00);
        chk("R1 a_pin_out", a_pin_out, 8'h00);
        chk("R1 irq", {6'd0, b_irq, a_irq}, 8'h00);
        chk("R1 aux_oe", {6'd0, b_aux_oe, a_aux_oe}, 8'h00);
        bus_rd(2'd1, v); chk("R1 ctrl A", v, 8'h00);
        bus_rd(2'd3, v); chk("R1 ctrl B", v, 8'h00);
        bus_rd(2'd0, v); chk("R1 ddr A", v, 8'h00);
    endtask

    task automatic t_commit_timing();
        @(negedge clk);
        sel = 1'b1; rd_wr = 1'b0; rs = 2'd0; wdata = 8'hF0; bus_phase = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 no change while strobe high", a_pin_oe, 8'h00);
        bus_phase = 1'b0; sel = 1'b0;
        @(negedge clk);
        chk("R4 no change one edge after fall", a_pin_oe, 8'h00);
        @(negedge clk);
        chk("R4 committed", a_pin_oe, 8'hF0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_port_a();
        logic [7:0] v;
        bus_rd(2'd0, v); chk("R3 ddr readback", v, 8'hF0);
        bus_wr(2'd1, 8'h04);
        bus_wr(2'd0, 8'hA5);
        chk("R2 oe", a_pin_oe, 8'hF0);
        chk("R2 out", a_pin_out, 8'hA0);
        a_pin_in = 8'h3C;
        bus_rd(2'd0, v); chk("R5 mixed read A", v, 8'hAC);
        bus_rd(2'd1, v); chk("R3 ctrl A read", v, 8'h04);
    endtask

    task automatic t_port_b();
        logic [7:0] v;
        bus_wr(2'd2, 8'h0F);
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd2, 8'h33);
        chk("R2 b oe", b_pin_oe, 8'h0F);
        chk("R2 b out", b_pin_out, 8'h03);
        chk("R11 a out kept", a_pin_out, 8'hA0);
        chk("R11 a oe kept", a_pin_oe, 8'hF0);
        b_pin_in = 8'hFF;
        bus_rd(2'd2, v); chk("R5 mixed read B", v, 8'hF3);
    endtask

    task automatic t_edge_input();
        logic [7:0] v;
        bus_wr(2'd1, 8'h05);
        a_edge_in = 1'b1; settle();
        bus_rd(2'd1, v); chk("R6 wrong edge ignored", v, 8'h05);
        a_edge_in = 1'b0; settle();
        chk("R6 irq on falling", {7'd0, a_irq}, 8'h01);
        chk("R11 b irq quiet", {7'd0, b_irq}, 8'h00);
        bus_rd(2'd1, v); chk("R9 ctrl read shows flag", v, 8'h85);
        chk("R9 ctrl read keeps irq", {7'd0, a_irq}, 8'h01);
        bus_rd(2'd0, v);
        bus_rd(2'd1, v); chk("R9 data read clears", v, 8'h05);
        chk("R9 irq low after clear", {7'd0, a_irq}, 8'h00);
        bus_wr(2'd1, 8'h06);
        a_edge_in = 1'b1; settle();
        chk("R6 masked irq", {7'd0, a_irq}, 8'h00);
        bus_rd(2'd1, v); chk("R6 rising flag", v, 8'h86);
        bus_wr(2'd1, 8'h44);
        bus_rd(2'd1, v); chk("R10 flag bits not writable", v, 8'h84);
        bus_rd(2'd0, v);
        bus_rd(2'd1, v); chk("R9 cleared again", v, 8'h04);
    endtask

    task automatic t_aux_input();
        logic [7:0] v;
        bus_wr(2'd1, 8'h1C);
        a_aux_in = 1'b1; settle();
        chk("R7 irq rising", {7'd0, a_irq}, 8'h01);
        bus_rd(2'd1, v); chk("R7 flag 2 set", v, 8'h5C);
        bus_rd(2'd0, v);
        bus_wr(2'd1, 8'h0C);
        a_aux_in = 1'b0; settle();
        bus_rd(2'd1, v); chk("R7 falling flag", v, 8'h4C);
        chk("R7 irq falling", {7'd0, a_irq}, 8'h01);
        bus_rd(2'd0, v);
        chk("R9 irq cleared", {7'd0, a_irq}, 8'h00);
    endtask

    task automatic t_aux_output();
        logic [7:0] v;
        bus_wr(2'd1, 8'h3C);
        chk("R8 driven", {6'd0, a_aux_oe, a_aux_out}, 8'h03);
        bus_wr(2'd1, 8'h34);
        chk("R8 low level", {6'd0, a_aux_oe, a_aux_out}, 8'h02);
        a_aux_in = 1'b1; settle();
        bus_rd(2'd1, v); chk("R8 no flag when driven", v, 8'h34);
        chk("R8 no irq when driven", {7'd0, a_irq}, 8'h00);
        bus_wr(2'd1, 8'h24);
        chk("R8 idle high", {6'd0, a_aux_oe, a_aux_out}, 8'h03);
        chk("R11 b aux idle", {6'd0, b_aux_oe, b_aux_out}, 8'h01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit_timing();
        t_port_a();
        t_port_b();
        t_edge_input();
        t_aux_input();
        t_aux_output();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule